// File: doc/BRIEF.md
# DDR SDRAM Command Decoder with Bank State Tracker

This block sits on the command side of a double-data-rate SDRAM model or monitor. On every rising clock edge it samples chip select, the row and column strobes, write enable, clock enable, the row/column address and the bank address. It turns them into a single decoded memory command, which appears one-hot on the outputs one cycle later. Alongside the command it reports the target bank and the two meanings of address bit 10: auto-precharge on a column access, and close-all on a precharge.

It also follows the state of every bank. For each bank it keeps an idle/active flag and the row that was opened. It checks each decoded command against that state and raises an illegal-command flag when the command does not fit. An access that asks for auto-precharge keeps its bank active for a fixed number of cycles, standing in for the burst, and then closes it. Data transfer, timing-parameter checks and mode-register contents are handled elsewhere.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: The pins sampled at a rising edge are decoded and shown on `cmd_onehot` after that edge. The pin patterns, as (row strobe, column strobe, write enable), are:
  - low/high/high is activate (bit 1)
  - high/low/high is read (bit 2)
  - high/low/low is write (bit 3)
  - low/high/low is precharge (bit 4)
  - low/low/high is refresh (bit 5)
  - any other pattern is no-operation (bit 0)
- R2: With chip select high, the cycle decodes as no-operation whatever the strobes are.
- R3: Clock enable low at an edge makes the command at the next edge decode as no-operation. The refresh pattern decodes as refresh only if clock enable is also high at that same edge; otherwise it is no-operation.
- R4: An activate to an idle bank sets that bank's active flag and loads its open-row register with the full address. The bank address appears on `cmd_bank`.
- R5: An activate to a bank that is already active raises `illegal` and leaves every bank's flag and row unchanged.
- R6: A read or write raises `illegal` and changes no state when its bank is idle or is already counting down to an auto-precharge.
- R7: A precharge closes the addressed bank. With address bit 10 high it closes all banks and sets `pre_all`. A precharge is always legal.
- R8: A legal read or write with address bit 10 high sets `auto_pre`. Its bank's active flag then falls AP_HOLD cycles after the access is shown on the outputs.
- R9: A refresh is legal only when every bank is idle; otherwise `illegal` is raised. Refresh never changes bank state.
- R10: Reset is synchronous and active high. It clears all outputs except `cmd_onehot`, which shows no-operation, and it clears every bank's state, including rows, to zero.
- R11: `cmd_bank` is zero for no-operation and refresh. `auto_pre` is set only on read or write, and `pre_all` only on precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| addr | input | ROW_W (13) | Row/column address; bit 10 is the precharge option |
| ba | input | BANK_AW (2) | Bank address |
| cmd_onehot | output | 6 | Decoded command, one-hot |
| cmd_bank | output | BANK_AW | Bank the decoded command targets |
| auto_pre | output | 1 | Read/write with auto-precharge |
| pre_all | output | 1 | Precharge applied to all banks |
| illegal | output | 1 | Command conflicts with the bank state |
| bank_active | output | BANKS (4) | Per-bank active flags |
| open_row | output | BANKS*ROW_W | Per-bank open-row registers, bank 0 in the low bits |

## Verification
The hardest state to reach is a bank that is still active but is in its auto-precharge countdown. A read or write to it must be refused, while a precharge must still cut the countdown short. Directed sequences issue an access with bit 10 high and then probe that bank on each cycle of the countdown. Random traffic is biased toward few banks and few opcodes, so that activates, accesses and precharges collide often. A second hard spot is the one-cycle delay of clock enable. The stimulus drops clock enable and then places a command that would otherwise open a bank, and it also places a refresh pattern in the same cycle that clock enable is low.

// File: rtl/ddr_cmd_pkg.sv
`timescale 1ns/1ps
package ddr_cmd_pkg;

    // Decoded operation; the value is also the bit position in the one-hot output.
    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ACT = 3'd1,
        OP_RD  = 3'd2,
        OP_WR  = 3'd3,
        OP_PRE = 3'd4,
        OP_REF = 3'd5
    } op_e;

    localparam int NUM_OPS = 6;
    localparam int OPT_BIT = 10;  // address bit carrying the precharge option

    // Registered view of one decoded command.
    typedef struct packed {
        op_e  op;
        logic opt;
        logic bad;
    } cmd_rec_t;

    function automatic logic [NUM_OPS-1:0] op_onehot(op_e op);
        logic [NUM_OPS-1:0] r;
        r = '0;
        r[int'(op)] = 1'b1;
        return r;
    endfunction

    function automatic logic is_column(op_e op);
        return (op == OP_RD) || (op == OP_WR);
    endfunction

endpackage

// File: rtl/ddr_cmd_decode.sv
`timescale 1ns/1ps
module ddr_cmd_decode
    import ddr_cmd_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic cke_now,
    input  logic cke_prev,
    output op_e  op
);
    always_comb begin
        op = OP_NOP;
        if (cke_prev && !cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  op = OP_ACT;
                3'b101:  op = OP_RD;
                3'b100:  op = OP_WR;
                3'b010:  op = OP_PRE;
                3'b001:  op = cke_now ? OP_REF : OP_NOP;
                default: op = OP_NOP;
            endcase
        end
    end
endmodule

// File: rtl/ddr_bank_slot.sv
`timescale 1ns/1ps
module ddr_bank_slot #(
    parameter int ROW_W = 13,
    parameter int HOLD  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_en,
    input  logic             close_en,
    input  logic             ap_en,
    input  logic [ROW_W-1:0] row_in,
    output logic             active,
    output logic             closing,
    output logic [ROW_W-1:0] row
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            closing <= 1'b0;
            cnt     <= '0;
            row     <= '0;
        end else if (close_en) begin
            active  <= 1'b0;
            closing <= 1'b0;
            cnt     <= '0;
        end else if (open_en) begin
            active  <= 1'b1;
            row     <= row_in;
        end else if (ap_en) begin
            closing <= 1'b1;
            cnt     <= CW'(HOLD - 1);
        end else if (closing) begin
            if (cnt == '0) begin
                active  <= 1'b0;
                closing <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/ddr_cmd_tracker.sv
`timescale 1ns/1ps
module ddr_cmd_tracker
    import ddr_cmd_pkg::*;
#(
    parameter int ROW_W   = 13,
    parameter int BANK_AW = 2,
    parameter int AP_HOLD = 4,
    localparam int BANKS  = 1 << BANK_AW
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic                   cke,
    input  logic [ROW_W-1:0]       addr,
    input  logic [BANK_AW-1:0]     ba,
    output logic [NUM_OPS-1:0]     cmd_onehot,
    output logic [BANK_AW-1:0]     cmd_bank,
    output logic                   auto_pre,
    output logic                   pre_all,
    output logic                   illegal,
    output logic [BANKS-1:0]       bank_active,
    output logic [BANKS*ROW_W-1:0] open_row
);
    logic             cke_q;
    op_e              op;
    logic             opt;
    logic             legal;
    logic [BANKS-1:0] closing;
    cmd_rec_t         rec_q;
    logic [BANK_AW-1:0] bank_q;

    assign opt = addr[OPT_BIT];

    ddr_cmd_decode u_dec (
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .cke_now  (cke),
        .cke_prev (cke_q),
        .op       (op)
    );

    // Legality against the bank state held before this edge.
    always_comb begin
        unique case (op)
            OP_ACT:       legal = !bank_active[ba];
            OP_RD, OP_WR: legal = bank_active[ba] && !closing[ba];
            OP_REF:       legal = (bank_active == '0);
            default:      legal = 1'b1;
        endcase
    end

    for (genvar i = 0; i < BANKS; i++) begin : g_bank
        logic hit;
        assign hit = (ba == BANK_AW'(i));

        ddr_bank_slot #(
            .ROW_W (ROW_W),
            .HOLD  (AP_HOLD)
        ) u_slot (
            .clk      (clk),
            .rst      (rst),
            .open_en  ((op == OP_ACT) && legal && hit),
            .close_en ((op == OP_PRE) && (opt || hit)),
            .ap_en    (is_column(op) && legal && opt && hit),
            .row_in   (addr),
            .active   (bank_active[i]),
            .closing  (closing[i]),
            .row      (open_row[i*ROW_W +: ROW_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cke_q  <= 1'b1;
            rec_q  <= '{op: OP_NOP, opt: 1'b0, bad: 1'b0};
            bank_q <= '0;
        end else begin
            cke_q     <= cke;
            rec_q.op  <= op;
            rec_q.opt <= opt && (is_column(op) || (op == OP_PRE));
            rec_q.bad <= !legal;
            bank_q    <= ((op == OP_NOP) || (op == OP_REF)) ? '0 : ba;
        end
    end

    assign cmd_onehot = op_onehot(rec_q.op);
    assign cmd_bank   = bank_q;
    assign auto_pre   = rec_q.opt && is_column(rec_q.op);
    assign pre_all    = rec_q.opt && (rec_q.op == OP_PRE);
    assign illegal    = rec_q.bad;
endmodule

// File: rtl/ddr_cmd_tracker_chk.sv
`timescale 1ns/1ps
module ddr_cmd_tracker_chk
    import ddr_cmd_pkg::*;
#(
    parameter int ROW_W   = 13,
    parameter int BANK_AW = 2,
    localparam int BANKS  = 1 << BANK_AW
) (
    input logic                   clk,
    input logic                   rst,
    input logic [ROW_W-1:0]       addr,
    input logic [NUM_OPS-1:0]     cmd_onehot,
    input logic [BANK_AW-1:0]     cmd_bank,
    input logic                   auto_pre,
    input logic                   pre_all,
    input logic                   illegal,
    input logic [BANKS-1:0]       bank_active,
    input logic [BANKS*ROW_W-1:0] open_row
);
    logic [BANKS-1:0] act_prev;

    always_ff @(posedge clk) begin
        if (rst) act_prev <= '0;
        else     act_prev <= bank_active;
    end

    // R1
    onehot_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(cmd_onehot) == 1);

    // R4
    act_opens_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_onehot[int'(OP_ACT)] && !illegal) |->
            (bank_active[cmd_bank] && open_row[cmd_bank*ROW_W +: ROW_W] == $past(addr)));

    // R6
    col_needs_open_chk: assert property (@(posedge clk) disable iff (rst)
        ((cmd_onehot[int'(OP_RD)] || cmd_onehot[int'(OP_WR)]) && !illegal) |->
            act_prev[cmd_bank]);

    // R7
    pre_all_closes_chk: assert property (@(posedge clk) disable iff (rst)
        pre_all |-> (bank_active == '0));

    // R7
    pre_never_bad_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_onehot[int'(OP_PRE)] || cmd_onehot[int'(OP_NOP)]) |-> !illegal);

    // R9
    ref_all_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_onehot[int'(OP_REF)] && !illegal) |-> (act_prev == '0));

    // R11
    ap_only_col_chk: assert property (@(posedge clk) disable iff (rst)
        auto_pre |-> (cmd_onehot[int'(OP_RD)] || cmd_onehot[int'(OP_WR)]));
endmodule

bind ddr_cmd_tracker ddr_cmd_tracker_chk #(
    .ROW_W   (ROW_W),
    .BANK_AW (BANK_AW)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .addr        (addr),
    .cmd_onehot  (cmd_onehot),
    .cmd_bank    (cmd_bank),
    .auto_pre    (auto_pre),
    .pre_all     (pre_all),
    .illegal     (illegal),
    .bank_active (bank_active),
    .open_row    (open_row)
);

// File: tb/ddr_cmd_tracker_bench.sv
`timescale 1ns/1ps
module ddr_cmd_tracker_bench;
    localparam int RW = 13;
    localparam int NB = 4;
    localparam int HOLD = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
    logic [RW-1:0] addr = '0;
    logic [1:0] ba = '0;
    logic [5:0] cmd_onehot;
    logic [1:0] cmd_bank;
    logic auto_pre, pre_all, illegal;
    logic [NB-1:0] bank_active;
    logic [NB*RW-1:0] open_row;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // model state
    bit m_act[NB];
    bit m_pend[NB];
    int m_cnt[NB];
    logic [RW-1:0] m_row[NB];
    bit m_cke = 1;
    int e_op;
    logic [1:0] e_bank;
    bit e_ap, e_pall, e_ill;

    always #5 clk = ~clk;

    ddr_cmd_tracker u_ddr_cmd_tracker (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .addr(addr), .ba(ba),
        .cmd_onehot(cmd_onehot), .cmd_bank(cmd_bank), .auto_pre(auto_pre),
        .pre_all(pre_all), .illegal(illegal), .bank_active(bank_active),
        .open_row(open_row)
    );

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // op codes: 0 nop 1 act 2 rd 3 wr 4 pre 5 ref
    function automatic int model_decode(bit cs, bit r, bit c, bit w, bit k);
        if (!m_cke || cs) return 0;
        case ({r, c, w})
            3'b011: return 1;
            3'b101: return 2;
            3'b100: return 3;
            3'b010: return 4;
            3'b001: return k ? 5 : 0;
            default: return 0;
        endcase
    endfunction

    task automatic model_step(bit cs, bit r, bit c, bit w, bit k, logic [RW-1:0] a, logic [1:0] b);
        bit any, legal, o;
        int op;
        op = model_decode(cs, r, c, w, k);
        o = a[10];
        any = 0;
        for (int i = 0; i < NB; i++) any |= m_act[i];
        case (op)
            1: legal = !m_act[b];
            2, 3: legal = m_act[b] && !m_pend[b];
            5: legal = !any;
            default: legal = 1;
        endcase
        e_op = op;
        e_bank = (op == 0 || op == 5) ? 2'd0 : b;
        e_ap = o && (op == 2 || op == 3);
        e_pall = o && (op == 4);
        e_ill = !legal;
        for (int i = 0; i < NB; i++) begin
            if (op == 4 && (o || b == 2'(i))) begin
                m_act[i] = 0; m_pend[i] = 0; m_cnt[i] = 0;
            end else if (op == 1 && legal && b == 2'(i)) begin
                m_act[i] = 1; m_row[i] = a;
            end else if ((op == 2 || op == 3) && legal && o && b == 2'(i)) begin
                m_pend[i] = 1; m_cnt[i] = HOLD - 1;
            end else if (m_pend[i]) begin
                if (m_cnt[i] == 0) begin m_act[i] = 0; m_pend[i] = 0; end
                else m_cnt[i]--;
            end
        end
        m_cke = k;
    endtask

    // Called at a negative edge; drives, clocks, checks at the next negative edge.
    task automatic cyc(input string tag, input bit cs, input bit r, input bit c, input bit w,
                       input bit k, input logic [RW-1:0] a, input logic [1:0] b);
        logic [NB-1:0] ea;
        cs_n = cs; ras_n = r; cas_n = c; we_n = w; cke = k; addr = a; ba = b;
        @(posedge clk);
        model_step(cs, r, c, w, k, a, b);
        @(negedge clk);
        chk(tag, "cmd_onehot", 64'(cmd_onehot), 64'(6'(1) << e_op));
        chk(tag, "cmd_bank", 64'(cmd_bank), 64'(e_bank));
        chk(tag, "auto_pre", 64'(auto_pre), 64'(e_ap));
        chk(tag, "pre_all", 64'(pre_all), 64'(e_pall));
        chk(tag, "illegal", 64'(illegal), 64'(e_ill));
        for (int i = 0; i < NB; i++) ea[i] = m_act[i];
        chk(tag, "bank_active", 64'(bank_active), 64'(ea));
        for (int i = 0; i < NB; i++)
            chk(tag, "open_row", 64'(open_row[i*RW +: RW]), 64'(m_row[i]));
    endtask

    // pin helpers: cmd(tag, op, a, b)
    task automatic cmd(input string tag, input int op, input logic [RW-1:0] a, input logic [1:0] b);
        case (op)
            1: cyc(tag, 0, 0, 1, 1, 1, a, b);
            2: cyc(tag, 0, 1, 0, 1, 1, a, b);
            3: cyc(tag, 0, 1, 0, 0, 1, a, b);
            4: cyc(tag, 0, 0, 1, 0, 1, a, b);
            5: cyc(tag, 0, 0, 0, 1, 1, a, b);
            default: cyc(tag, 0, 1, 1, 1, 1, a, b);
        endcase
    endtask

    localparam logic [RW-1:0] A10 = 13'h0400;

    initial begin
        for (int i = 0; i < NB; i++) begin
            m_act[i] = 0; m_pend[i] = 0; m_cnt[i] = 0; m_row[i] = '0;
        end
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk("R10", "cmd_onehot", 64'(cmd_onehot), 64'd1);
        chk("R10", "bank_active", 64'(bank_active), 64'd0);
        chk("R10", "open_row", 64'(open_row), 64'd0);
        chk("R10", "flags", 64'({illegal, auto_pre, pre_all, cmd_bank}), 64'd0);

        cyc("R2", 1, 0, 1, 1, 1, 13'h0123, 2'd1);      // ACT pins deselected
        cmd("R4", 1, 13'h1ABC, 2'd1);
        cmd("R5", 1, 13'h0555, 2'd1);                  // double activate
        cmd("R6", 2, 13'h0000, 2'd2);                  // read idle bank
        cmd("R6", 3, 13'h0000, 2'd0);                  // write idle bank
        cmd("R8", 2, A10, 2'd1);                       // read + auto-precharge
        cmd("R8", 3, 13'h0000, 2'd1);                  // write during countdown
        cmd("R8", 0, '0, 2'd0);
        cmd("R8", 0, '0, 2'd0);
        cmd("R8", 0, '0, 2'd0);
        cmd("R8", 2, '0, 2'd1);                        // bank now closed
        cmd("R9", 5, '0, 2'd3);                        // refresh all idle
        cmd("R4", 1, 13'h0FFF, 2'd0);
        cmd("R9", 5, '0, 2'd0);                        // refresh with open bank
        cmd("R11", 4, '0, 2'd0);                       // single precharge
        cyc("R3", 0, 1, 1, 1, 0, '0, 2'd0);            // cke low
        cyc("R3", 0, 0, 1, 1, 1, 13'h0777, 2'd3);      // ignored activate
        cyc("R3", 0, 0, 0, 1, 0, '0, 2'd0);            // refresh pattern with cke low
        cyc("R3", 0, 1, 1, 1, 1, '0, 2'd0);
        cyc("R1", 0, 0, 0, 0, 1, A10, 2'd2);           // unlisted pattern
        cmd("R4", 1, 13'h1000, 2'd2);
        cmd("R4", 1, 13'h0001, 2'd3);
        cmd("R8", 3, A10, 2'd3);                       // write + auto-precharge
        cmd("R7", 4, '0, 2'd3);                        // precharge cuts countdown
        cmd("R7", 4, A10, 2'd0);                       // precharge all
        cmd("R11", 0, A10, 2'd3);

        // constrained random traffic
        for (int n = 0; n < 600; n++) begin
            int sel;
            logic [RW-1:0] a;
            logic [1:0] b;
            sel = int'($urandom % 16);
            a = RW'($urandom);
            b = 2'($urandom % 3);
            if (sel < 1)       cyc("R2", 1, 2'($urandom) == 0, 0, 1, 1, a, b);
            else if (sel < 2)  cyc("R3", 0, 1, 1, 1, 0, a, b);
            else if (sel < 3)  cyc("R1", 0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), a, b);
            else if (sel < 7)  cmd("R4", 1, a, b);
            else if (sel < 11) cmd("R6", 2 + int'($urandom % 2), a, b);
            else if (sel < 14) cmd("R7", 4, (($urandom % 4) == 0) ? (a | A10) : (a & ~A10), b);
            else if (sel < 15) cmd("R9", 5, a, b);
            else               cmd("R1", 0, a, b);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule